// File: doc/BRIEF.md
# Ethernet Preamble Synchronizer

This block sits directly after the clock-recovery stage of a 10 Mb/s Ethernet receiver. It takes a serial bit stream in which each recovered bit is marked by a one-clock strobe and qualified by carrier sense. When carrier arrives, the block skips a fixed run of bit times so that the recovery loop can settle. It then searches for the pair of adjacent ones that closes the preamble. If a pair of adjacent zeros shows up before that pair, the frame is rejected and the block stays quiet until carrier goes away.

Once the preamble has ended, every following bit is packed into bytes. The first bit received becomes the least significant bit of a byte. Each complete byte is presented with a single-clock valid strobe. The block signals the end of the frame when carrier drops, and it flags any trailing bits that do not fill a whole byte; those bits are never delivered. Address filtering, CRC checking and buffering belong to the blocks downstream.

Top module: `psync_top`

## Requirements
- R1: While rst_n is low, and on the first clock after it rises, byte_valid, frame_start, frame_end, pre_err and dribble are all 0.
- R2: A clock with bit_valid low has no effect: rx_bit and carrier are not looked at, and no output changes because of that clock.
- R3: The strobed bit that first shows carrier high and the next BLANK_BITS-1 strobed bits (16 bits by default) are ignored, whatever their values, including "11" or "00" pairs.
- R4: After the blanking window, the first pair of adjacent strobed bits equal to 1,1 ends the preamble. frame_start pulses for one clock, in the clock after the strobe of the second 1. The bit strobed next is bit 0 of the first byte.
- R5: If an adjacent 0,0 pair appears after the blanking window and before any 1,1 pair, pre_err pulses for one clock. The block then produces no frame_start, byte or frame_end until a strobe with carrier low has been seen.
- R6: Data bits are packed least significant first: the first bit of a group of eight lands in byte_data[0] and the eighth in byte_data[7]. byte_valid pulses for one clock, in the clock after the strobe of the eighth bit, with byte_data holding that byte.
- R7: A strobe with carrier low while bytes are being assembled makes frame_end pulse for one clock in the following clock. If 1 to 7 bits of an unfinished byte are pending, dribble pulses in that same clock, and those bits are not delivered on byte_data.
- R8: A strobe with carrier low during the blanking window or the preamble search returns the block to waiting for carrier. It produces no frame_end, pre_err or dribble, and a new frame can then be received normally.
- R9: Every output strobe lasts exactly one clock. Consecutive byte_valid pulses are separated by at least seven clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | One-clock strobe marking a recovered bit time |
| carrier | input | 1 | Carrier sense, sampled on strobed clocks |
| rx_bit | input | 1 | Recovered serial data bit |
| byte_data | output | 8 | Assembled byte, least significant bit received first |
| byte_valid | output | 1 | One-clock strobe for a completed byte |
| frame_start | output | 1 | One-clock pulse when the end-of-preamble pair is found |
| frame_end | output | 1 | One-clock pulse when carrier drops during data |
| pre_err | output | 1 | One-clock pulse when a zero pair precedes the one pair |
| dribble | output | 1 | One-clock pulse, alongside frame_end, for a partial final byte |

## Verification
The search is driven with a full 64-bit preamble, with a shortened preamble, with a run of sixteen ones and with a run of sixteen zeros placed inside the blanking window. Comparing these shows whether the window length is exact and whether pairs inside it are really ignored. Asymmetric byte values such as 0x1E and 0x80 tell least-significant-first packing apart from the reverse order, and they also reveal a one-bit slip in where data starts. A zero pair after the window, followed by a false one pair while carrier stays high, checks the abort and the wait for carrier loss. Frames with three trailing bits, frames lost during the search, and frames whose strobes are separated by idle clocks carrying junk separate the dribble, silent-return and strobe-qualification behaviour.

// File: rtl/psync_pkg.sv
package psync_pkg;
  parameter int unsigned BYTE_W = 8;
  localparam int unsigned BCNT_W = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BLANK = 3'd1,
    ST_HUNT  = 3'd2,
    ST_DATA  = 3'd3,
    ST_ABORT = 3'd4
  } sync_st_e;

  // New bit enters at the top; after BYTE_W steps the first bit sits in bit 0.
  function automatic logic [BYTE_W-1:0] shift_lsb_first(input logic [BYTE_W-1:0] sr,
                                                        input logic b);
    return {b, sr[BYTE_W-1:1]};
  endfunction

  function automatic logic last_blank_bit(input int unsigned cnt, input int unsigned span);
    return (cnt == span - 1);
  endfunction

  function automatic logic last_byte_bit(input logic [BCNT_W-1:0] cnt);
    return (cnt == BCNT_W'(BYTE_W - 1));
  endfunction
endpackage

// File: rtl/psync_blank.sv
module psync_blank import psync_pkg::*; #(
  parameter int unsigned BLANK_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic step,
  output logic done_now
);
  localparam int unsigned CW = $clog2(BLANK_BITS + 1);

  logic [CW-1:0] cnt;

  initial assert (BLANK_BITS >= 2);

  assign done_now = step && last_blank_bit(int'(cnt), BLANK_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (start)    cnt <= CW'(1);
    else if (done_now) cnt <= '0;
    else if (step)     cnt <= cnt + CW'(1);
  end

  // R3: the window counter never exceeds the window length
  p_blank_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < BLANK_BITS);
endmodule

// File: rtl/psync_pair.sv
module psync_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic bit_in,
  output logic hit_ones,
  output logic hit_zeros
);
  logic prev_bit;
  logic prev_ok;

  assign hit_ones  = step && prev_ok &&  prev_bit &&  bit_in;
  assign hit_zeros = step && prev_ok && !prev_bit && !bit_in;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      prev_bit <= 1'b0;
      prev_ok  <= 1'b0;
    end else if (step) begin
      prev_bit <= bit_in;
      prev_ok  <= 1'b1;
    end
  end

  // R4: a pair match needs a stored first bit from an earlier step
  p_pair_prev_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ones || hit_zeros) |-> $past(step || prev_ok));
endmodule

// File: rtl/psync_deser.sv
module psync_deser import psync_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] data,
  output logic              byte_done,
  output logic              partial
);
  logic [BYTE_W-1:0] sr;
  logic [BCNT_W-1:0] cnt;
  logic [BYTE_W-1:0] sr_next;

  assign sr_next = shift_lsb_first(sr, bit_in);
  assign partial = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr        <= '0;
      cnt       <= '0;
      data      <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (clear) begin
        cnt <= '0;
      end else if (step) begin
        sr <= sr_next;
        if (last_byte_bit(cnt)) begin
          cnt       <= '0;
          data      <= sr_next;
          byte_done <= 1'b1;
        end else begin
          cnt <= cnt + BCNT_W'(1);
        end
      end
    end
  end

  // R9: a byte strobe is never followed by another in the next clock
  p_byte_spaced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);
  // R6: a byte completes only after a data step
  p_byte_from_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(step));
endmodule

// File: rtl/psync_top.sv
module psync_top import psync_pkg::*; #(
  parameter int unsigned BLANK_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              carrier,
  input  logic              rx_bit,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_valid,
  output logic              frame_start,
  output logic              frame_end,
  output logic              pre_err,
  output logic              dribble
);
  sync_st_e state, state_nx;

  // named internal events
  logic ev_bit, ev_drop;
  logic blank_start, blank_step, blank_done;
  logic pair_clear, pair_step, hit_ones, hit_zeros;
  logic deser_clear, deser_step, deser_partial;

  assign ev_bit  = bit_valid &&  carrier;
  assign ev_drop = bit_valid && !carrier;

  assign blank_start = (state == ST_IDLE)  && ev_bit;
  assign blank_step  = (state == ST_BLANK) && ev_bit;
  assign pair_clear  = (state != ST_HUNT);
  assign pair_step   = (state == ST_HUNT)  && ev_bit;
  assign deser_clear = (state != ST_DATA);
  assign deser_step  = (state == ST_DATA)  && ev_bit;

  psync_blank #(.BLANK_BITS(BLANK_BITS)) u_blank (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (blank_start),
    .step     (blank_step),
    .done_now (blank_done)
  );

  psync_pair u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (pair_clear),
    .step      (pair_step),
    .bit_in    (rx_bit),
    .hit_ones  (hit_ones),
    .hit_zeros (hit_zeros)
  );

  psync_deser u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (deser_clear),
    .step      (deser_step),
    .bit_in    (rx_bit),
    .data      (byte_data),
    .byte_done (byte_valid),
    .partial   (deser_partial)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (ev_bit)          state_nx = ST_BLANK;
      ST_BLANK: if (ev_drop)         state_nx = ST_IDLE;
                else if (blank_done) state_nx = ST_HUNT;
      ST_HUNT:  if (ev_drop)         state_nx = ST_IDLE;
                else if (hit_ones)   state_nx = ST_DATA;
                else if (hit_zeros)  state_nx = ST_ABORT;
      ST_DATA:  if (ev_drop)         state_nx = ST_IDLE;
      ST_ABORT: if (ev_drop)         state_nx = ST_IDLE;
      default:                       state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
      pre_err     <= 1'b0;
      dribble     <= 1'b0;
    end else begin
      state       <= state_nx;
      frame_start <= (state == ST_HUNT) && !ev_drop && hit_ones;
      pre_err     <= (state == ST_HUNT) && !ev_drop && hit_zeros;
      frame_end   <= (state == ST_DATA) && ev_drop;
      dribble     <= (state == ST_DATA) && ev_drop && deser_partial;
    end
  end

  // R4: start of frame only comes out of the preamble search
  p_start_from_hunt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(state == ST_HUNT));
  // R7: dribble is only reported together with the frame end
  p_dribble_with_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dribble |-> frame_end);
  // R8: frame end only from the data phase
  p_end_from_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> $past(state == ST_DATA));
  // R5: an abort is never followed by a byte in the next clock
  p_no_byte_after_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_err |=> !byte_valid);
  // R9: frame-level strobes last a single clock
  p_start_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  p_end_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);
  // R2: unstrobed clocks leave the state untouched
  p_idle_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_valid) && $past(rst_n) |-> $stable(state));
endmodule

// File: tb/test_psync_top.sv
module test_psync_top;
  logic clk = 1'b0;
  logic rst_n, bit_valid, carrier, rx_bit;
  logic [7:0] byte_data;
  logic byte_valid, frame_start, frame_end, pre_err, dribble;

  int n_checks = 0, n_fail = 0;
  int gap = 0;
  int n_bytes, n_start, n_end, n_err, n_drib;
  logic [7:0] got [0:63];

  always #5 clk = ~clk;

  psync_top i_psync_top (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .carrier(carrier),
    .rx_bit(rx_bit), .byte_data(byte_data), .byte_valid(byte_valid),
    .frame_start(frame_start), .frame_end(frame_end), .pre_err(pre_err),
    .dribble(dribble)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) begin
        if (n_bytes < 64) got[n_bytes] = byte_data;
        n_bytes++;
      end
      if (frame_start) n_start++;
      if (frame_end)   n_end++;
      if (pre_err)     n_err++;
      if (dribble)     n_drib++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_bytes = 0; n_start = 0; n_end = 0; n_err = 0; n_drib = 0;
  endtask

  // one strobed bit, optionally followed by unstrobed clocks with junk on the lines
  task automatic sb(input logic b, input logic c);
    bit_valid = 1'b1; carrier = c; rx_bit = b;
    @(negedge clk);
    for (int g = 0; g < gap; g++) begin
      bit_valid = 1'b0; carrier = g[0]; rx_bit = ~b;
      @(negedge clk);
    end
    bit_valid = 1'b0;
  endtask

  task automatic send_alt(input int n, input logic first);
    for (int i = 0; i < n; i++) sb(first ^ i[0], 1'b1);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sb(v[i], 1'b1);
  endtask

  task automatic end_pair(input string req);
    sb(1'b1, 1'b1);
    bit_valid = 1'b1; carrier = 1'b1; rx_bit = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
    check(req, frame_start, 1);
    for (int g = 0; g < gap; g++) begin
      carrier = 1'b0; rx_bit = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic drop();
    sb(1'b0, 1'b0);
  endtask

  task automatic t_reset();
    bit_valid = 0; carrier = 0; rx_bit = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 byte_valid", byte_valid, 0);
    check("R1 frame_start", frame_start, 0);
    check("R1 pulses", frame_end | pre_err | dribble, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", byte_valid | frame_start | frame_end | pre_err | dribble, 0);
  endtask

  task automatic t_normal();
    clear_counts();
    send_alt(62, 1'b1);
    end_pair("R4 start timing full preamble");
    for (int i = 0; i < 7; i++) sb(1'b0, 1'b1);
    bit_valid = 1'b1; carrier = 1'b1; rx_bit = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
    check("R6 byte_valid timing", byte_valid, 1);
    check("R6 byte 0x80", byte_data, 8'h80);
    send_byte(8'h1E);
    send_byte(8'hFF);
    drop();
    check("R7 frame_end timing", frame_end, 1);
    check("R7 no dribble on whole bytes", dribble, 0);
    @(negedge clk);
    check("R6 byte count", n_bytes, 3);
    check("R6 lsb first 0x1E", got[1], 8'h1E);
    check("R6 byte 0xFF", got[2], 8'hFF);
    check("R9 one start", n_start, 1);
    check("R9 one end", n_end, 1);
  endtask

  task automatic t_short_pre();
    clear_counts();
    send_alt(20, 1'b1);
    end_pair("R4 start after short preamble");
    send_byte(8'h5C);
    drop();
    @(negedge clk);
    check("R4 short preamble byte", got[0], 8'h5C);
    check("R4 short preamble count", n_bytes, 1);
  endtask

  task automatic t_ones_in_blank();
    clear_counts();
    for (int i = 0; i < 16; i++) sb(1'b1, 1'b1);
    check("R3 ones in window ignored", n_start, 0);
    send_alt(9, 1'b0);
    check("R3 no early start", n_start, 0);
    end_pair("R3 start after window");
    send_byte(8'h3A);
    drop();
    @(negedge clk);
    check("R3 alignment after ones", got[0], 8'h3A);
  endtask

  task automatic t_zeros_in_blank();
    clear_counts();
    for (int i = 0; i < 16; i++) sb(1'b0, 1'b1);
    sb(1'b1, 1'b1); sb(1'b0, 1'b1);
    check("R3 zeros in window ignored", n_err, 0);
    end_pair("R3 start after zero window");
    send_byte(8'h01);
    drop();
    @(negedge clk);
    check("R3 zero window byte", got[0], 8'h01);
  endtask

  task automatic t_abort();
    clear_counts();
    send_alt(16, 1'b1);
    sb(1'b1, 1'b1);
    sb(1'b0, 1'b1);
    sb(1'b0, 1'b1);
    check("R5 pre_err timing", pre_err, 1);
    sb(1'b1, 1'b1); sb(1'b1, 1'b1);
    send_byte(8'hAA);
    send_byte(8'h55);
    check("R5 no start after abort", n_start, 0);
    check("R5 no bytes after abort", n_bytes, 0);
    drop();
    @(negedge clk);
    check("R5 no frame_end after abort", n_end, 0);
    check("R5 one error", n_err, 1);
    clear_counts();
    send_alt(40, 1'b1);
    end_pair("R5 recovery start");
    send_byte(8'hC4);
    drop();
    @(negedge clk);
    check("R5 recovery byte", got[0], 8'hC4);
  endtask

  task automatic t_dribble();
    clear_counts();
    send_alt(30, 1'b1);
    end_pair("R4 start before dribble");
    send_byte(8'h12);
    send_byte(8'h34);
    sb(1'b1, 1'b1); sb(1'b1, 1'b1); sb(1'b0, 1'b1);
    drop();
    check("R7 frame_end with partial", frame_end, 1);
    check("R7 dribble flag", dribble, 1);
    @(negedge clk);
    check("R7 partial not output", n_bytes, 2);
    check("R7 second byte", got[1], 8'h34);
  endtask

  task automatic t_drop_early();
    clear_counts();
    send_alt(10, 1'b1);
    drop();
    send_alt(24, 1'b1);
    drop();
    @(negedge clk);
    check("R8 silent drop pulses", n_end + n_err + n_drib + n_start, 0);
    send_alt(26, 1'b1);
    end_pair("R8 start after silent drops");
    send_byte(8'h9B);
    drop();
    @(negedge clk);
    check("R8 byte after drops", got[0], 8'h9B);
    check("R8 single end", n_end, 1);
  endtask

  task automatic t_gaps();
    clear_counts();
    gap = 3;
    send_alt(22, 1'b1);
    end_pair("R2 start with gaps");
    send_byte(8'h6D);
    send_byte(8'hF0);
    drop();
    gap = 0;
    @(negedge clk);
    check("R2 gap byte count", n_bytes, 2);
    check("R2 gap byte 0", got[0], 8'h6D);
    check("R2 gap byte 1", got[1], 8'hF0);
    check("R2 gap end count", n_end, 1);
  endtask

  initial begin
    clear_counts();
    t_reset();
    t_normal();
    t_short_pre();
    t_ones_in_blank();
    t_zeros_in_blank();
    t_abort();
    t_dribble();
    t_drop_early();
    t_gaps();
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule